// File: doc/BRIEF.md
# Two-Channel Volume Command Slave

This block is the control front end of a stereo digital volume stage. It watches a two-wire serial bus (SCL and SDA, both open-drain with pull-ups) using the system clock, finds start and stop conditions, and accepts write transfers addressed to its fixed device address. Each byte after the address is acknowledged and decoded into a change of the left and/or right attenuation setting, or of a mute flag shared by both channels.

Attenuation is kept per channel as two digits: a tens digit (0 to 7) and a units digit (0 to 9). The block presents each channel's total, ten times the tens digit plus the units digit, as a value from 0 to 79 dB. The attenuator that uses these values lies outside the block. The block does not support read transfers or clock stretching. The only pin it drives is an enable that pulls SDA low.

Top module: `vol_cmd_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start that arrives mid-transfer (repeated start) begins a new address phase. After a stop, `sda_oe` is 0.
- R2: Only the address byte 0x88 is acknowledged, with `sda_oe`=1 through the ninth SCL clock. For any other address `sda_oe` stays 0 on that clock. All further bytes are then neither acknowledged nor applied until the next start.
- R3: After a matched address, any number of data bytes may follow before the stop. Each byte is acknowledged and applied in order.
- R4: A units command writes its lower nibble (0 to 9) as the units digit. Upper nibble 0xA targets left, 0x2 targets right, and 0xD targets both channels.
- R5: A tens command needs bit 3 equal to 0 and writes bits 2:0 (0 to 7) as the tens digit. Upper nibble 0xB targets left, 0x3 targets right, and 0xE targets both channels.
- R6: `left_atten` and `right_atten` each equal 10 × tens + units for their channel, and never exceed 79.
- R7: Byte 0xFF sets both channels to tens 7 and units 9 (79 dB).
- R8: Byte 0x78 clears `mute` and byte 0x79 sets it. The flag applies to both channels.
- R9: A units command with a value above 9, or a tens command with bit 3 set, is acknowledged but changes no output.
- R10: After reset, both attenuation outputs read 79, `mute` is 0 and `sda_oe` is 0.
- R11: A byte takes effect only on the rising SCL edge of its ninth (acknowledge) clock. A byte cut short by a stop or a start changes no output.
- R12: A data byte with any other upper nibble (other than 0x78, 0x79 and 0xFF) is acknowledged and changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| left_atten | output | 7 | Left channel attenuation in dB, 0 to 79 |
| right_atten | output | 7 | Right channel attenuation in dB, 0 to 79 |
| mute | output | 1 | Shared mute flag |

## Verification
The hardest cases to reach from the pins are those where the bus is interrupted: a data byte cut short by a stop after only a few bits, and a repeated start that arrives before any stop. In both cases the state left in the shifter must not leak into the outputs. The bench reaches these cases with bus tasks that can stop after any bit count and can begin a new start straight after an acknowledge. A mismatched address followed by a mute-setting byte shows that the ignore state blocks both the acknowledge and the update.

// File: rtl/vol_pkg.sv
package vol_pkg;

  localparam int ATT_W = 7;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_t;

  // Update request derived from one command byte
  typedef struct packed {
    logic       l_units;
    logic       l_tens;
    logic       r_units;
    logic       r_tens;
    logic       max_all;
    logic       mute_wr;
    logic [3:0] val;
    logic       mute_val;
  } upd_t;

  function automatic logic units_ok(input logic [3:0] v);
    return v <= 4'd9;
  endfunction

  function automatic logic tens_ok(input logic [3:0] v);
    return !v[3];
  endfunction

  function automatic upd_t decode_cmd(input logic [7:0] b);
    upd_t u;
    u          = '0;
    u.val      = b[3:0];
    u.mute_val = b[0];
    if (b == 8'hFF) begin
      u.max_all = 1'b1;
    end else if (b[7:1] == 7'b0111_100) begin
      u.mute_wr = 1'b1;
    end else begin
      case (b[7:4])
        4'hA: u.l_units = units_ok(b[3:0]);
        4'h2: u.r_units = units_ok(b[3:0]);
        4'hD: begin
          u.l_units = units_ok(b[3:0]);
          u.r_units = units_ok(b[3:0]);
        end
        4'hB: u.l_tens = tens_ok(b[3:0]);
        4'h3: u.r_tens = tens_ok(b[3:0]);
        4'hE: begin
          u.l_tens = tens_ok(b[3:0]);
          u.r_tens = tens_ok(b[3:0]);
        end
        default: ;
      endcase
    end
    return u;
  endfunction

  function automatic logic [ATT_W-1:0] atten_db(input logic [2:0] tens,
                                                input logic [3:0] units);
    logic [ATT_W-1:0] t;
    t = {{(ATT_W-3){1'b0}}, tens};
    return (t << 3) + (t << 1) + {{(ATT_W-4){1'b0}}, units};
  endfunction

endpackage

// File: rtl/bus_cond_det.sv
module bus_cond_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain   <= '1;
          prev[g] <= 1'b1;
        end else begin
          chain   <= {chain[STAGES-2:0], raw[g]};
          prev[g] <= chain[STAGES-1];
        end
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  assign scl_q     = synced[0];
  assign sda_q     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/byte_rx.sv
module byte_rx
  import vol_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h88
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_oe,
  output logic       byte_commit,
  output logic [7:0] rx_byte,
  output logic       skipping
);
  localparam int BITS  = 8;
  localparam int CNT_W = $clog2(BITS + 2);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BITS + 1);

  rx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= RX_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      sda_oe      <= 1'b0;
      byte_commit <= 1'b0;
    end else begin
      byte_commit <= 1'b0;
      if (start_det) begin
        st     <= RX_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= RX_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (st != RX_IDLE) begin
        if (scl_rise) begin
          if (cnt < ACK_BIT) begin
            shreg <= {shreg[6:0], sda_q};
            cnt   <= cnt + 1'b1;
          end else if (cnt == ACK_BIT) begin
            cnt <= ACK_DONE;
            if (sda_oe && st == RX_DATA) byte_commit <= 1'b1;
          end
        end else if (scl_fall) begin
          if (cnt == ACK_BIT) begin
            if (st == RX_ADDR) begin
              if (shreg == DEV_ADDR) sda_oe <= 1'b1;
              else                   st     <= RX_SKIP;
            end else if (st == RX_DATA) begin
              sda_oe <= 1'b1;
            end
          end else if (cnt == ACK_DONE) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (st == RX_ADDR) st <= RX_DATA;
          end
        end
      end
    end
  end

  assign rx_byte  = shreg;
  assign skipping = (st == RX_SKIP);
endmodule

// File: rtl/atten_regs.sv
module atten_regs
  import vol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_commit,
  input  logic [7:0]       rx_byte,
  output logic [ATT_W-1:0] left_atten,
  output logic [ATT_W-1:0] right_atten,
  output logic             mute
);
  localparam logic [2:0] TENS_MAX  = 3'd7;
  localparam logic [3:0] UNITS_MAX = 4'd9;

  upd_t       upd;
  logic [2:0] l_tens, r_tens;
  logic [3:0] l_units, r_units;

  assign upd = decode_cmd(rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_tens  <= TENS_MAX;
      r_tens  <= TENS_MAX;
      l_units <= UNITS_MAX;
      r_units <= UNITS_MAX;
      mute    <= 1'b0;
    end else if (byte_commit) begin
      if (upd.max_all) begin
        l_tens  <= TENS_MAX;
        r_tens  <= TENS_MAX;
        l_units <= UNITS_MAX;
        r_units <= UNITS_MAX;
      end
      if (upd.mute_wr) mute    <= upd.mute_val;
      if (upd.l_units) l_units <= upd.val;
      if (upd.r_units) r_units <= upd.val;
      if (upd.l_tens)  l_tens  <= upd.val[2:0];
      if (upd.r_tens)  r_tens  <= upd.val[2:0];
    end
  end

  assign left_atten  = atten_db(l_tens, l_units);
  assign right_atten = atten_db(r_tens, r_units);
endmodule

// File: rtl/vol_cmd_slave.sv
module vol_cmd_slave
  import vol_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR    = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [ATT_W-1:0] left_atten,
  output logic [ATT_W-1:0] right_atten,
  output logic             mute
);
  logic       scl_q, sda_q;
  logic       scl_rise, scl_fall;
  logic       start_det, stop_det;
  logic       byte_commit;
  logic [7:0] rx_byte;
  logic       skipping;

  bus_cond_det #(.STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  byte_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_q       (sda_q),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_oe      (sda_oe),
    .byte_commit (byte_commit),
    .rx_byte     (rx_byte),
    .skipping    (skipping)
  );

  atten_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_commit (byte_commit),
    .rx_byte     (rx_byte),
    .left_atten  (left_atten),
    .right_atten (right_atten),
    .mute        (mute)
  );

  logic unused_scl;
  assign unused_scl = scl_q;
endmodule

// File: rtl/vol_cmd_chk.sv
module vol_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [6:0] left_atten,
  input logic [6:0] right_atten,
  input logic       mute,
  input logic       scl_fall,
  input logic       stop_det,
  input logic       byte_commit,
  input logic [7:0] rx_byte,
  input logic       skipping
);
  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R2
  AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_commit |=> ($stable(left_atten) && $stable(right_atten) && $stable(mute))); // R11
  AST_ATTEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (left_atten <= 7'd79) && (right_atten <= 7'd79)); // R6
  AST_SKIP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> (!byte_commit && !sda_oe)); // R2
  AST_MUTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_commit && rx_byte == 8'h79) |=> mute); // R8
  AST_MAX_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_commit && rx_byte == 8'hFF) |=> (left_atten == 7'd79 && right_atten == 7'd79)); // R7
endmodule

bind vol_cmd_slave vol_cmd_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe      (sda_oe),
  .left_atten  (left_atten),
  .right_atten (right_atten),
  .mute        (mute),
  .scl_fall    (scl_fall),
  .stop_det    (stop_det),
  .byte_commit (byte_commit),
  .rx_byte     (rx_byte),
  .skipping    (skipping)
);

// File: tb/sim_vol_cmd_slave.sv
`timescale 1ns/1ps
module sim_vol_cmd_slave;
  localparam int HALF = 10;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_oe;
  logic [6:0] left_atten, right_atten;
  logic       mute;
  logic       sda_line;
  int         n_run = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  assign sda_line = sda_drv & ~sda_oe;

  always #10 clk = ~clk;

  vol_cmd_slave u0 (
    .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_line),
    .sda_oe (sda_oe), .left_atten (left_atten), .right_atten (right_atten), .mute (mute)
  );

  // {cmd, left, right, mute, requirement}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'hA3, 7'd73, 7'd79, 1'b0, 4'd4},
    {8'hB1, 7'd13, 7'd79, 1'b0, 4'd5},
    {8'h25, 7'd13, 7'd75, 1'b0, 4'd4},
    {8'h30, 7'd13, 7'd5,  1'b0, 4'd5},
    {8'hD7, 7'd17, 7'd7,  1'b0, 4'd4},
    {8'hE4, 7'd47, 7'd47, 1'b0, 4'd6},
    {8'h79, 7'd47, 7'd47, 1'b1, 4'd8},
    {8'h78, 7'd47, 7'd47, 1'b0, 4'd8},
    {8'hAC, 7'd47, 7'd47, 1'b0, 4'd9},
    {8'hB8, 7'd47, 7'd47, 1'b0, 4'd9},
    {8'h50, 7'd47, 7'd47, 1'b0, 4'd12},
    {8'hFF, 7'd79, 7'd79, 1'b0, 4'd7},
    {8'hE0, 7'd9,  7'd9,  1'b0, 4'd5},
    {8'hD0, 7'd0,  7'd0,  1'b0, 4'd6}
  };

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wait_clk(HALF);
    scl = 1'b1;     wait_clk(HALF);
    sda_drv = 1'b0; wait_clk(HALF);
    scl = 1'b0;     wait_clk(HALF);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_clk(HALF);
    scl = 1'b1;     wait_clk(HALF);
    sda_drv = 1'b1; wait_clk(4 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_drv = b[i]; wait_clk(HALF);
      scl = 1'b1;     wait_clk(HALF);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_drv = 1'b1; wait_clk(HALF);
    scl = 1'b1;     wait_clk(HALF / 2);
    ack = ~sda_line; wait_clk(HALF / 2);
    scl = 1'b0;
  endtask

  task automatic check_outs(input string req, input int l, input int r, input int m);
    check(req, "left_atten", int'(left_atten), l);
    check(req, "right_atten", int'(right_atten), r);
    check(req, "mute", int'(mute), m);
  endtask

  initial begin : watchdog
    #3_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic a;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R10 reset state
    check_outs("R10", 79, 79, 0);
    check("R10", "sda_oe", int'(sda_oe), 0);

    // table walk: one command per transfer
    for (int v = 0; v < NVEC; v++) begin
      bus_start();
      send_byte(8'h88, a);
      check("R2", "addr ack", int'(a), 1);
      send_byte(VEC[v][26:19], a);
      check(req_name(int'(VEC[v][3:0])), "data ack", int'(a), 1);
      bus_stop();
      check_outs(req_name(int'(VEC[v][3:0])), int'(VEC[v][18:12]),
                 int'(VEC[v][11:5]), int'(VEC[v][4]));
      check("R1", "sda_oe after stop", int'(sda_oe), 0);
    end

    // R2 wrong address, following byte ignored
    bus_start();
    send_byte(8'h90, a);
    check("R2", "foreign addr ack", int'(a), 0);
    send_byte(8'h79, a);
    check("R2", "ignored data ack", int'(a), 0);
    bus_stop();
    check_outs("R2", 0, 0, 0);

    // R3 several bytes in one transfer
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'hA1, a); check("R3", "byte1 ack", int'(a), 1);
    send_byte(8'hB2, a); check("R3", "byte2 ack", int'(a), 1);
    send_byte(8'h35, a); check("R3", "byte3 ack", int'(a), 1);
    bus_stop();
    check_outs("R3", 21, 50, 0);

    // R11 byte cut short by stop
    bus_start();
    send_byte(8'h88, a);
    send_bits(8'h79, 4);
    bus_stop();
    check_outs("R11", 21, 50, 0);

    // R11 byte cut short by repeated start
    bus_start();
    send_byte(8'h88, a);
    send_bits(8'hD3, 6);
    bus_start();
    send_byte(8'h88, a);
    check("R11", "addr ack after restart", int'(a), 1);
    bus_stop();
    check_outs("R11", 21, 50, 0);

    // R1 repeated start without stop
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'hA9, a);
    bus_start();
    send_byte(8'h88, a);
    check("R1", "ack after repeated start", int'(a), 1);
    send_byte(8'h20, a);
    bus_stop();
    check_outs("R1", 29, 50, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule